// File: doc/BRIEF.md
# Converter Serial Readout Controller

This block is the digital half of a self-timed, low-power converter that is read through a chip-select, a serial clock and a three-state data line. It runs a repeating cycle of three phases: a conversion of fixed length, a sleep phase that holds the finished result, and a data-output phase that shifts the result out. Successive conversions alternate between two input channels. A stub input supplies the conversion code, and a cycle counter stands in for the conversion time.

The serial clock can be driven by the block (internal mode) or by the host (external mode). The mode is taken from the level of the serial-clock line in the first clock after reset and again at every falling edge of chip-select. Chip-select has two jobs. Pulling it low wakes a sleeping block and enables the data line. Raising it during data output abandons the frame and starts a fresh conversion. When chip-select is low outside data output, the data line shows whether a result is ready.

Top module: `adc_readout_ctrl`

## Requirements
- R1: `sdo_oe` is 0 whenever `cs_n` is 1 and 1 whenever `cs_n` is 0.
- R2: With `cs_n` low and no frame in progress, `sdo` is 1 while a conversion runs and 0 while a finished result waits in sleep.
- R3: A conversion lasts exactly CONV_CYCLES clock cycles and then captures `conv_code`. The block then sleeps while `cs_n` is high. A low `cs_n` in sleep starts data output on the next clock.
- R4: A frame is CODE_W+1 bits, most significant first: the channel bit (0 = channel 0, 1 = channel 1), then the captured code. Each bit changes only after a falling SCK edge, so it is stable at each rising edge.
- R5: A rising `cs_n` during data output drops the rest of the frame and starts a new conversion on the next clock. The dropped result is never sent again.
- R6: The clock mode is captured from the SCK line in the first clock after reset and at each falling edge of `cs_n`: 1 selects internal mode, 0 selects external mode. The mode does not change at any other time. `sck_pullup_en` shows the current mode (1 = internal).
- R7: In internal mode, `sck_oe` is 1 only during data output. `sck_out` then idles low and has a period of 2*SCK_HALF clocks.
- R8: In external mode, `sck_oe` stays 0. Each falling edge on `sck_in` during data output moves to the next bit, and rising edges do not move the frame.
- R9: The first conversion after reset uses channel 0, and each later conversion uses the other channel. `conv_chan` shows the channel being converted or next to convert.
- R10: When the last bit of a frame has been clocked out, a new conversion starts on its own even if `cs_n` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip-select: wakes the block and aborts a frame |
| sck_in | input | 1 | Level of the serial-clock line |
| conv_code | input | CODE_W | Stub conversion result |
| sck_out | output | 1 | Serial clock driven in internal mode |
| sck_oe | output | 1 | Drive enable for `sck_out` |
| sck_pullup_en | output | 1 | Pull-up enable for the SCK line; high in internal mode |
| sdo | output | 1 | Serial data or ready/busy status |
| sdo_oe | output | 1 | Drive enable for `sdo`; low means high impedance |
| conv_chan | output | 1 | Channel of the current or next conversion |

## Verification
The assertions check the phase sequencing on every cycle. They cover the exact conversion length, wake-up from sleep, abort on a rising chip-select, the channel toggling once per finished conversion, the mode register changing only at boot or at a chip-select fall, and data staying still across each internal rising clock edge. Only the bench scenarios can show the values in the frame. These include the channel bit and the result code under both clock modes, the internal clock period, the ready/busy levels seen on the data line, the mode chosen at reset, and the rule that an aborted result is replaced by a fresh conversion and is never sent again.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
   typedef enum logic [1:0] {
      ST_CONV  = 2'd0,
      ST_SLEEP = 2'd1,
      ST_DATA  = 2'd2
   } rd_state_e;
endpackage

// File: rtl/adc_conv_timer.sv
// Counts the conversion interval; done is high in the last cycle of it.
module adc_conv_timer #(
   parameter int CONV_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   localparam int CW = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1;

   logic [CW-1:0] cnt_q;

   assign done = run && (cnt_q == CW'(CONV_CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (run && !done)  cnt_q <= cnt_q + 1'b1;
      else                    cnt_q <= '0;
   end
endmodule

// File: rtl/adc_sck_divider.sv
// Generates the internal serial clock, low first, half period HALF clocks.
module adc_sck_divider #(
   parameter int HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sck,
   output logic fall
);
   logic tick;
   logic sck_q;

   if (HALF == 1) begin : g_div_bypass
      assign tick = 1'b1;
   end else begin : g_div_count
      localparam int DW = $clog2(HALF);
      logic [DW-1:0] div_q;
      assign tick = (div_q == DW'(HALF - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             div_q <= '0;
         else if (!run || tick)  div_q <= '0;
         else                    div_q <= div_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sck_q <= 1'b0;
      else if (!run)  sck_q <= 1'b0;
      else if (tick)  sck_q <= ~sck_q;
   end

   assign sck  = sck_q;
   assign fall = run && tick && sck_q;
endmodule

// File: rtl/adc_frame_shifter.sv
// Holds the outgoing frame and counts the bits already presented.
module adc_frame_shifter #(
   parameter int FRAME_W = 21
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] load_word,
   input  logic               shift,
   output logic               msb,
   output logic               last
);
   localparam int BW = $clog2(FRAME_W);

   logic [FRAME_W-1:0] sh_q;
   logic [BW-1:0]      bit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         bit_q <= '0;
      end else if (load) begin
         sh_q  <= load_word;
         bit_q <= '0;
      end else if (shift) begin
         sh_q  <= sh_q << 1;
         bit_q <= bit_q + 1'b1;
      end
   end

   assign msb  = sh_q[FRAME_W-1];
   assign last = (bit_q == BW'(FRAME_W - 1));
endmodule

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl #(
   parameter int CODE_W      = 20,
   parameter int CONV_CYCLES = 64,
   parameter int SCK_HALF    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sck_in,
   input  logic [CODE_W-1:0] conv_code,
   output logic              sck_out,
   output logic              sck_oe,
   output logic              sck_pullup_en,
   output logic              sdo,
   output logic              sdo_oe,
   output logic              conv_chan
);
   import adc_rd_pkg::*;

   localparam int FRAME_W = CODE_W + 1;

   if (CODE_W < 1) begin : g_bad_code_w
      $error("CODE_W must be at least 1");
   end
   if (CONV_CYCLES < 2) begin : g_bad_conv
      $error("CONV_CYCLES must be at least 2");
   end
   if (SCK_HALF < 1) begin : g_bad_half
      $error("SCK_HALF must be at least 1");
   end

   rd_state_e state_q, state_d;
   logic cs_q, sck_q, boot_q, int_mode_q, chan_q;
   logic cs_fall, cs_rise, in_data, conv_done;
   logic int_fall, ext_fall, adv, last, msb, shift;

   assign cs_fall  = cs_q & ~cs_n;
   assign cs_rise  = ~cs_q & cs_n;
   assign in_data  = (state_q == ST_DATA);
   assign ext_fall = in_data && !int_mode_q && sck_q && !sck_in;
   assign adv      = int_mode_q ? int_fall : ext_fall;
   assign shift    = adv && !last && !cs_rise;

   adc_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) i_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (state_q == ST_CONV),
      .done  (conv_done)
   );

   adc_sck_divider #(.HALF(SCK_HALF)) i_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (in_data && int_mode_q),
      .sck   (sck_out),
      .fall  (int_fall)
   );

   adc_frame_shifter #(.FRAME_W(FRAME_W)) i_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (conv_done),
      .load_word ({chan_q, conv_code}),
      .shift     (shift),
      .msb       (msb),
      .last      (last)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_CONV:  if (conv_done) state_d = ST_SLEEP;
         ST_SLEEP: if (!cs_n)     state_d = ST_DATA;
         ST_DATA:  if (cs_rise || (adv && last)) state_d = ST_CONV;
         default:  state_d = ST_CONV;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_CONV;
         cs_q       <= 1'b1;
         sck_q      <= 1'b0;
         boot_q     <= 1'b1;
         int_mode_q <= 1'b0;
         chan_q     <= 1'b0;
      end else begin
         state_q <= state_d;
         cs_q    <= cs_n;
         sck_q   <= sck_in;
         boot_q  <= 1'b0;
         if (boot_q || cs_fall) int_mode_q <= sck_in;
         if (conv_done)         chan_q     <= ~chan_q;
      end
   end

   assign sdo_oe        = ~cs_n;
   assign sdo           = in_data ? msb : (state_q == ST_CONV);
   assign sck_oe        = in_data && int_mode_q;
   assign sck_pullup_en = int_mode_q;
   assign conv_chan     = chan_q;
endmodule

// File: rtl/adc_readout_chk.sv
module adc_readout_chk #(
   parameter int CONV_CYCLES = 64
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cs_n,
   input logic                  sdo,
   input logic                  sck_out,
   input logic                  sck_oe,
   input logic                  sck_pullup_en,
   input logic                  conv_chan,
   input adc_rd_pkg::rd_state_e state,
   input logic                  boot
);
   import adc_rd_pkg::*;

   int unsigned conv_len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                conv_len_q <= 0;
      else if (state == ST_CONV) conv_len_q <= conv_len_q + 1;
      else                       conv_len_q <= 0;
   end

   assert_conv_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CONV) |-> (conv_len_q < CONV_CYCLES));

   assert_conv_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CONV && conv_len_q != CONV_CYCLES - 1) |=> (state == ST_CONV));

   assert_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SLEEP && !cs_n) |=> (state == ST_DATA));

   assert_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DATA && $rose(cs_n)) |=> (state == ST_CONV));

   assert_mode_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!boot && !$fell(cs_n)) |=> $stable(sck_pullup_en));

   assert_sdo_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DATA && $past(state) == ST_DATA && $rose(sck_out)) |-> $stable(sdo));

   assert_sck_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sck_oe |-> (state == ST_DATA && sck_pullup_en));

   assert_chan_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CONV) |=> ((state == ST_SLEEP) == (conv_chan != $past(conv_chan))));

   assert_chan_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_CONV) |=> $stable(conv_chan));
endmodule

bind adc_readout_ctrl adc_readout_chk #(.CONV_CYCLES(CONV_CYCLES)) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cs_n          (cs_n),
   .sdo           (sdo),
   .sck_out       (sck_out),
   .sck_oe        (sck_oe),
   .sck_pullup_en (sck_pullup_en),
   .conv_chan     (conv_chan),
   .state         (state_q),
   .boot          (boot_q)
);

// File: tb/test_adc_readout_ctrl.sv
module test_adc_readout_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int CW         = 20;
   localparam int CONV       = 8;
   localparam int HALF       = 2;
   localparam int NVEC       = 6;

   // each entry: {mode (1 = internal SCK), code}
   localparam logic [CW:0] VEC [NVEC] = '{
      {1'b1, 20'hABCDE}, {1'b0, 20'h12345}, {1'b1, 20'h00000},
      {1'b0, 20'hFFFFF}, {1'b1, 20'h80001}, {1'b0, 20'h5A5A5}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1;
   logic sck_drv = 1'b1;
   logic [CW-1:0] conv_code = '0;
   logic sck_out, sck_oe, sck_pullup_en, sdo, sdo_oe, conv_chan;
   logic sck_line;
   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   assign sck_line = sck_oe ? sck_out : sck_drv;

   always #(CLK_PERIOD / 2) clk = ~clk;

   adc_readout_ctrl #(.CODE_W(CW), .CONV_CYCLES(CONV), .SCK_HALF(HALF)) i_adc_readout_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .cs_n          (cs_n),
      .sck_in        (sck_line),
      .conv_code     (conv_code),
      .sck_out       (sck_out),
      .sck_oe        (sck_oe),
      .sck_pullup_en (sck_pullup_en),
      .sdo           (sdo),
      .sdo_oe        (sdo_oe),
      .conv_chan     (conv_chan)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic read_int(output logic [CW:0] w);
      logic prev;
      logic seen;
      int gap;
      prev = sck_out;
      gap = 0;
      for (int b = CW; b >= 0; b--) begin
         seen = 1'b0;
         while (!seen) begin
            @(negedge clk);
            gap++;
            seen = sck_out && !prev;
            prev = sck_out;
         end
         if (b < CW) chk("R7 internal SCK period", gap, 2 * HALF);
         gap = 0;
         w[b] = sdo;
      end
      chk("R7 sck_oe in internal frame", sck_oe, 1);
      while (sck_oe) @(negedge clk);
   endtask

   task automatic read_ext(input int nbits, output logic [CW:0] w);
      w = '0;
      for (int b = CW; b > CW - nbits; b--) begin
         @(negedge clk) sck_drv = 1'b1;
         @(negedge clk);
         @(negedge clk);
         w[b] = sdo;
         @(negedge clk) sck_drv = 1'b0;
      end
      chk("R8 sck_oe low in external mode", sck_oe, 0);
      @(negedge clk);
   endtask

   task automatic busy_after_frame();
      chk("R10 sdo_oe after frame", sdo_oe, 1);
      chk("R10 busy after complete frame", sdo, 1);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      logic [CW:0] w;
      logic [CW-1:0] nxt;
      logic mode;
      conv_code = VEC[0][CW-1:0];
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      chk("R1 sdo_oe at reset", sdo_oe, 0);
      chk("R7 sck_oe at reset", sck_oe, 0);
      chk("R9 conv_chan at reset", conv_chan, 0);

      for (int i = 0; i < NVEC; i++) begin
         mode = VEC[i][CW];
         repeat (CONV + 4) @(negedge clk);
         chk("R1 sdo_oe with cs high", sdo_oe, 0);
         chk("R9 conv_chan after conversion", conv_chan, ((i + 1) % 2));
         sck_drv = mode;
         cs_n = 1'b0;
         #1;
         chk("R1 sdo_oe with cs low", sdo_oe, 1);
         chk("R2 ready status", sdo, 0);
         nxt = (i < NVEC - 1) ? VEC[i + 1][CW-1:0] : 20'h3C3C3;
         conv_code = nxt;
         if (mode) read_int(w);
         else      read_ext(CW + 1, w);
         chk("R9 channel bit", w[CW], (i % 2));
         chk("R4 frame code", w[CW-1:0], VEC[i][CW-1:0]);
         chk("R6 mode from SCK at cs fall", sck_pullup_en, mode);
         busy_after_frame();
         @(negedge clk) cs_n = 1'b1;
         #1;
         chk("R1 sdo_oe after cs rise", sdo_oe, 0);
      end

      // abort in the middle of an external-clock frame
      repeat (CONV + 4) @(negedge clk);
      sck_drv = 1'b0;
      cs_n = 1'b0;
      #1;
      conv_code = 20'h0F0F0;
      read_ext(5, w);
      chk("R4 partial frame head", w[CW:CW-4], 5'b0_0011);
      @(negedge clk) cs_n = 1'b1;
      #1;
      chk("R1 sdo_oe on abort", sdo_oe, 0);
      @(negedge clk) cs_n = 1'b0;
      #1;
      chk("R5 new conversion after abort", sdo, 1);
      repeat (CONV - 1) @(negedge clk);
      chk("R3 still busy in last conversion cycle", sdo, 1);
      @(negedge clk);
      chk("R3 ready after conversion length", sdo, 0);
      read_ext(CW + 1, w);
      chk("R5 fresh frame after abort", w, {1'b1, 20'h0F0F0});
      busy_after_frame();
      @(negedge clk) cs_n = 1'b1;

      // clock mode capture at reset
      @(negedge clk) begin rst_n = 1'b0; sck_drv = 1'b0; end
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R6 external mode captured at reset", sck_pullup_en, 0);
      rst_n = 1'b0;
      sck_drv = 1'b1;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R6 internal mode captured at reset", sck_pullup_en, 1);
      chk("R9 conv_chan after reset", conv_chan, 0);
      chk("R1 sdo_oe after reset", sdo_oe, 0);
      sck_drv = 1'b0;
      repeat (3) @(negedge clk);
      chk("R6 mode held without cs fall", sck_pullup_en, 1);
      cs_n = 1'b0;
      #1;
      chk("R2 busy status while converting", sdo, 1);
      @(negedge clk);
      chk("R6 mode recaptured at cs fall", sck_pullup_en, 0);

      if (!done) begin
         done = 1;
         summary();
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end
endmodule